// File: doc/BRIEF.md
# Calibrated Seconds Tick Generator

This block divides a slow oscillator clock, nominally around 33.33 kHz, down to a one-second strobe. A calibration word sets the length of a second. Its low field is a whole count of oscillator ticks. A small fractional field adds one extra tick to a chosen number of seconds out of every sixteen. The combination lets long-term drift be trimmed finer than one tick per second. The running tick count is available for readback. Software can use it, together with the strobe, to time sub-second intervals.

Writing a new calibration word has two effects. It restarts the current second from tick zero, so the next strobe arrives exactly one programmed period after the write. It also restarts the sixteen-second fractional cycle. When the oscillator enable is low, counting freezes and no strobe is produced.

Counting is controlled by a two-state machine:

- **ST_BASE** counts the whole ticks of the second.
- **ST_STRETCH** is the single appended tick of a lengthened second.

Its transitions are as follows:

- **ST_BASE to ST_BASE (finish):** taken when the second ends and needs no extra tick.
- **ST_BASE to ST_STRETCH (lengthen):** taken when the whole ticks are used up and the current second is one of those that get an extra tick.
- **ST_STRETCH to ST_BASE (finish):** taken on the next enabled tick.
- **Any state to ST_BASE (restart):** taken on a calibration write.

Top module: `sec_tick_gen`

## Requirements
- R1: After reset, the tick count is 0, the strobe is low, and the calibration word is 0x198233. With the enable high from reset, the first second therefore lasts 0x8234 = 33332 oscillator cycles.
- R2: The strobe is high for one cycle at the end of each second. The tick count reads 0 in that cycle. With fraction enable (word bit 20) clear and a whole count T (word bits 15:0) of at least 2, the strobe repeats every T enabled cycles.
- R3: Within a second, the tick count rises by exactly one on each enabled cycle.
- R4: With fraction enable set and fraction value N (word bits 19:16), the block counts seconds 0 to 15 and then wraps to 0. Seconds 0 to N-1 of each cycle last T+1 cycles and the rest last T cycles. N = 0 adds no extra tick.
- R5: With fraction enable clear, the fraction value has no effect on any second's length.
- R6: A calibration write forces the tick count to 0 and the strobe low in the following cycle. It restarts the sixteen-second cycle at second 0. The next strobe comes exactly one period of the new word after the write.
- R7: Only bits 20:0 of the written data are stored. Bits above 20 are ignored.
- R8: While the enable is low, the tick count and the second index hold their values and no strobe is produced. The second is lengthened by exactly the number of disabled cycles.
- R9: A whole count of 0 or 1 gives a one-cycle second, plus one cycle when the second is lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_wdata | input | 32 | Calibration write data; only bits 20:0 are kept |
| cal_we | input | 1 | Calibration write strobe |
| osc_en | input | 1 | Count enable |
| sec_pulse | output | 1 | One-cycle end-of-second strobe |
| tick_count | output | 16 | Current tick count within the second |

## Verification
The whole count is tried with the fractional path off, a small fraction value and a zero fraction value. Comparing these separates a plain divider from one that lengthens the right seconds of the sixteen-second cycle. A fraction value with its enable clear, and write data with only the upper bits set, show whether ignored fields leak into the period. Restart writes issued in the middle of a second and in the middle of the fractional cycle distinguish a true restart from one that keeps the old count or the old second index. An enable gap in the middle of a second, and counts of 0 and 1, check the hold behaviour and the degenerate lengths.

// File: rtl/sec_tick_pkg.sv
package sec_tick_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [0:0] {
        ST_BASE    = 1'b0,
        ST_STRETCH = 1'b1
    } tick_state_e;

    localparam int unsigned TICK_W_DEF   = 16;
    localparam int unsigned FRAC_W_DEF   = 4;
    localparam int unsigned CAL_IN_W_DEF = 32;
endpackage

// File: rtl/sec_cal_reg.sv
module sec_cal_reg #(
    parameter int unsigned TICK_W   = 16,
    parameter int unsigned FRAC_W   = 4,
    parameter int unsigned CAL_IN_W = 32,
    parameter logic [TICK_W+FRAC_W:0] CAL_RESET = 21'h198233
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CAL_IN_W-1:0] wdata,
    output logic [TICK_W-1:0]   ticks,
    output logic [FRAC_W-1:0]   frac_val,
    output logic                frac_en
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CAL_W    = TICK_W + FRAC_W + 1;
    localparam int unsigned FRAC_LSB = TICK_W;
    localparam int unsigned EN_BIT   = TICK_W + FRAC_W;

    logic [CAL_W-1:0] cal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cal_q <= CAL_RESET;
        else if (we) cal_q <= wdata[CAL_W-1:0];
    end

    assign ticks    = cal_q[TICK_W-1:0];
    assign frac_val = cal_q[FRAC_LSB +: FRAC_W];
    assign frac_en  = cal_q[EN_BIT];

    // R7
    cal_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cal_q == $past(wdata[CAL_W-1:0])));
endmodule

// File: rtl/sec_frac_sched.sv
module sec_frac_sched #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              sec_done,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] frac_val,
    output logic              stretch
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [FRAC_W-1:0] sec_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sec_idx <= '0;
        else if (restart)  sec_idx <= '0;
        else if (sec_done) sec_idx <= sec_idx + 1'b1;
    end

    assign stretch = frac_en && (sec_idx < frac_val);

    // R4
    idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_done && !restart) |=> (sec_idx == $past(sec_idx) + 1'b1));

    // R6
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (sec_idx == '0));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_done && !restart) |=> $stable(sec_idx));
endmodule

// File: rtl/sec_tick_fsm.sv
module sec_tick_fsm
    import sec_tick_pkg::*;
#(
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              en,
    input  logic [TICK_W-1:0] ticks,
    input  logic              stretch,
    output logic              sec_done,
    output logic              sec_pulse,
    output logic [TICK_W-1:0] tick_count
);
    timeunit 1ns;
    timeprecision 1ps;

    tick_state_e       state_q, state_d;
    logic [TICK_W-1:0] cnt_d;
    logic              pulse_d;
    logic [TICK_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, tick_count} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BASE;
            tick_count <= '0;
            sec_pulse  <= 1'b0;
        end else begin
            state_q    <= state_d;
            tick_count <= cnt_d;
            sec_pulse  <= pulse_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = tick_count;
        pulse_d  = 1'b0;
        sec_done = 1'b0;
        if (restart) begin
            state_d = ST_BASE;
            cnt_d   = '0;
        end else if (en) begin
            unique case (state_q)
                ST_BASE: begin
                    if (cnt_inc >= {1'b0, ticks}) begin
                        if (stretch) begin
                            state_d = ST_STRETCH;
                            cnt_d   = cnt_inc[TICK_W-1:0];
                        end else begin
                            sec_done = 1'b1;
                            pulse_d  = 1'b1;
                            cnt_d    = '0;
                        end
                    end else begin
                        cnt_d = cnt_inc[TICK_W-1:0];
                    end
                end
                ST_STRETCH: begin
                    state_d  = ST_BASE;
                    sec_done = 1'b1;
                    pulse_d  = 1'b1;
                    cnt_d    = '0;
                end
                default: begin
                    state_d = ST_BASE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // R2
    pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (tick_count == '0));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart) |=> ((tick_count == $past(tick_count) + 1'b1) || (tick_count == '0)));

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> ($stable(tick_count) && !sec_pulse));

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((tick_count == '0) && !sec_pulse && (state_q == ST_BASE)));
endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen
    import sec_tick_pkg::*;
#(
    parameter int unsigned TICK_W   = TICK_W_DEF,
    parameter int unsigned FRAC_W   = FRAC_W_DEF,
    parameter int unsigned CAL_IN_W = CAL_IN_W_DEF,
    parameter logic [TICK_W+FRAC_W:0] CAL_RESET = 21'h198233
) (
    input  logic                clk_osc,
    input  logic                rst_n,
    input  logic [CAL_IN_W-1:0] cal_wdata,
    input  logic                cal_we,
    input  logic                osc_en,
    output logic                sec_pulse,
    output logic [TICK_W-1:0]   tick_count
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [TICK_W-1:0] ticks;
    logic [FRAC_W-1:0] frac_val;
    logic              frac_en;
    logic              stretch;
    logic              sec_done;

    sec_cal_reg #(
        .TICK_W(TICK_W), .FRAC_W(FRAC_W), .CAL_IN_W(CAL_IN_W), .CAL_RESET(CAL_RESET)
    ) u_cal (
        .clk(clk_osc), .rst_n(rst_n), .we(cal_we), .wdata(cal_wdata),
        .ticks(ticks), .frac_val(frac_val), .frac_en(frac_en)
    );

    sec_frac_sched #(.FRAC_W(FRAC_W)) u_sched (
        .clk(clk_osc), .rst_n(rst_n), .restart(cal_we), .sec_done(sec_done),
        .frac_en(frac_en), .frac_val(frac_val), .stretch(stretch)
    );

    sec_tick_fsm #(.TICK_W(TICK_W)) u_fsm (
        .clk(clk_osc), .rst_n(rst_n), .restart(cal_we), .en(osc_en),
        .ticks(ticks), .stretch(stretch), .sec_done(sec_done),
        .sec_pulse(sec_pulse), .tick_count(tick_count)
    );
endmodule

// File: tb/test_sec_tick_gen.sv
module test_sec_tick_gen;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk_osc = 1'b0;
    logic        rst_n   = 1'b0;
    logic [31:0] cal_wdata = '0;
    logic        cal_we  = 1'b0;
    logic        osc_en  = 1'b0;
    logic        sec_pulse;
    logic [15:0] tick_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_osc = ~clk_osc;

    sec_tick_gen i_sec_tick_gen (
        .clk_osc(clk_osc), .rst_n(rst_n), .cal_wdata(cal_wdata), .cal_we(cal_we),
        .osc_en(osc_en), .sec_pulse(sec_pulse), .tick_count(tick_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // counts negedges until a strobe is seen
    task automatic next_period(output int p);
        p = 0;
        do begin
            @(negedge clk_osc);
            p++;
        end while (!sec_pulse && p < 70000);
    endtask

    task automatic write_cal(input logic [31:0] w);
        cal_wdata = w;
        cal_we = 1'b1;
        @(negedge clk_osc);
        cal_we = 1'b0;
    endtask

    task automatic t_reset_default;
        int p;
        chk("R1", "reset tick_count", int'(tick_count), 0);
        chk("R1", "reset pulse", int'(sec_pulse), 0);
        osc_en = 1'b1;
        rst_n = 1'b1;
        next_period(p);
        chk("R1", "default first second", p, 33332);
    endtask

    task automatic t_plain;
        int p;
        write_cal(32'h0000_000A);
        chk("R6", "count after write", int'(tick_count), 0);
        chk("R6", "pulse after write", int'(sec_pulse), 0);
        next_period(p);
        chk("R2", "plain period", p, 10);
        for (int i = 1; i < 10; i++) begin
            @(negedge clk_osc);
            chk("R3", "count step", int'(tick_count), i);
            chk("R2", "pulse one cycle", int'(sec_pulse), 0);
        end
        next_period(p);
        chk("R2", "plain period repeat", p, 1);
    endtask

    task automatic t_frac(input int nval);
        int p;
        write_cal(32'h0010_0005 | (nval << 16));
        for (int s = 0; s < 17; s++) begin
            next_period(p);
            chk("R4", "fraction second", p, ((s % 16) < nval) ? 6 : 5);
        end
    endtask

    task automatic t_frac_off;
        int p;
        write_cal(32'h000F_0005);
        for (int s = 0; s < 16; s++) begin
            next_period(p);
            chk("R5", "fraction disabled", p, 5);
        end
    endtask

    task automatic t_restart;
        int p;
        write_cal(32'h0000_0014);
        repeat (9) @(negedge clk_osc);
        chk("R3", "mid count", int'(tick_count), 9);
        write_cal(32'h0011_0007);
        chk("R6", "count after mid write", int'(tick_count), 0);
        next_period(p);
        chk("R6", "first after mid write", p, 8);
        next_period(p);
        chk("R4", "second after write", p, 7);
        write_cal(32'h0011_0007);
        next_period(p);
        chk("R6", "index restarted", p, 8);
    endtask

    task automatic t_upper;
        int p;
        write_cal(32'hFFE0_000A);
        for (int s = 0; s < 3; s++) begin
            next_period(p);
            chk("R7", "upper bits ignored", p, 10);
        end
    endtask

    task automatic t_hold;
        int p;
        write_cal(32'h0000_000C);
        repeat (4) @(negedge clk_osc);
        chk("R8", "count before hold", int'(tick_count), 4);
        osc_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_osc);
            chk("R8", "held count", int'(tick_count), 4);
            chk("R8", "no pulse in hold", int'(sec_pulse), 0);
        end
        osc_en = 1'b1;
        next_period(p);
        chk("R8", "stretched by hold", p + 9, 17);
    endtask

    task automatic t_tiny;
        int p;
        write_cal(32'h0000_0000);
        next_period(p);
        chk("R9", "zero count period", p, 1);
        next_period(p);
        chk("R9", "zero count repeat", p, 1);
        write_cal(32'h0000_0001);
        next_period(p);
        chk("R9", "one count period", p, 1);
        write_cal(32'h0011_0001);
        next_period(p);
        chk("R9", "one count stretched", p, 2);
        next_period(p);
        chk("R9", "one count unstretched", p, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk_osc);
        t_reset_default();
        t_plain();
        t_frac(3);
        t_frac(0);
        t_frac_off();
        t_restart();
        t_upper();
        t_hold();
        t_tiny();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule